// File: doc/BRIEF.md
# PS/2 Mouse Command Responder

This block stands in for the command side of a standard PS/2 pointing device. A keyboard controller forwards host-to-mouse command bytes to it over a valid/ready byte input. The block keeps the device configuration: a status byte, a resolution value and a sample rate. For each byte it receives, it emits the reply bytes on a valid/ready output stream that feeds the controller's auxiliary receive queue.

Every received byte is answered with the acknowledge code 0xFA first. Some commands append further reply bytes after it. Two commands take a one-byte argument, and the next byte received is treated as that argument. Replies that span several bytes leave one byte per completed output transfer. The input stays closed until the whole reply of the previous byte has left the block.

Top module: `ps2_mouse_responder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_ready` is 1. The configuration is status 0x00, resolution 2 and sample rate 100, so a status report issued first returns FA 00 02 64.
- R2: Every accepted input byte produces 0xFA as its first response byte. Any other reply bytes come after it.
- R3: Command 0xE6 clears status bit 4 (mask 0x10). The reply is 0xFA alone.
- R4: Command 0xF4 sets status bit 5 (mask 0x20), and command 0xF5 clears it. Each is answered with 0xFA alone.
- R5: Command 0xE9 replies with four bytes in this order: 0xFA, the status byte, the resolution, the sample rate.
- R6: Command 0xF2 replies with 0xFA followed by the device ID 0x00.
- R7: Commands 0xF6 and 0xFF each reply 0xFA alone and restore status 0x00, resolution 2 and sample rate 100.
- R8: After command 0xE8, the next accepted byte becomes the resolution. After command 0xF3, the next accepted byte becomes the sample rate. In both cases that argument byte is answered with 0xFA alone and is never decoded as a command, even if it matches a command code.
- R9: Any other command byte is answered with 0xFA alone and leaves the configuration unchanged.
- R10: While any response byte is pending, `cmd_ready` is 0. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Input byte offered |
| cmd_ready | output | 1 | Block can accept an input byte |
| cmd_byte | input | 8 | Command or argument byte |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_byte | output | 8 | Response byte |

## Verification
The hardest situation to reach is an argument byte whose value equals a command code, for example 0xFF or 0xE9 arriving right after 0xF3 or 0xE8. A decoder that ignores the argument-wait state would reset the configuration or emit a status report at that point. Directed sequences create exactly those pairs. The random phase draws command codes with high weight, so an argument-taking command is often followed by another code. Every configuration change is then read back through a later status report. A randomly stalled `rsp_ready` exercises the output hold rule and the closed input across multi-byte replies.

// File: rtl/ps2_mouse_responder.sv
module ps2_mouse_responder #(
  parameter logic [7:0] DEF_RES  = 8'd2,
  parameter logic [7:0] DEF_RATE = 8'd100,
  parameter int         DEPTH    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_byte
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] ACK = 8'hFA;
  localparam logic [7:0] BIT_SCALE = 8'h10;
  localparam logic [7:0] BIT_REPORT = 8'h20;

  typedef enum logic [1:0] {W_NONE, W_RES, W_RATE} wait_t;

  logic [7:0]    rq [DEPTH];
  logic [CW-1:0] cnt;
  logic [7:0]    status, res, rate;
  wait_t         argw;

  wire take = cmd_valid && cmd_ready;
  wire give = rsp_valid && rsp_ready;

  assign cmd_ready = (cnt == '0);
  assign rsp_valid = (cnt != '0);
  assign rsp_byte  = rq[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rq[i] <= '0;
      cnt    <= '0;
      status <= '0;
      res    <= DEF_RES;
      rate   <= DEF_RATE;
      argw   <= W_NONE;
    end else begin
      if (give) begin
        for (int i = 0; i < DEPTH - 1; i++) rq[i] <= rq[i+1];
        cnt <= cnt - CW'(1);
      end
      if (take) begin
        rq[0] <= ACK;
        cnt   <= CW'(1);
        argw  <= W_NONE;
        if (argw == W_RES) res <= cmd_byte;
        else if (argw == W_RATE) rate <= cmd_byte;
        else begin
          case (cmd_byte)
            8'hE6: status <= status & ~BIT_SCALE;
            8'hE8: argw <= W_RES;
            8'hE9: begin
              rq[1] <= status;
              rq[2] <= res;
              rq[3] <= rate;
              cnt   <= CW'(4);
            end
            8'hF2: begin
              rq[1] <= 8'h00;
              cnt   <= CW'(2);
            end
            8'hF3: argw <= W_RATE;
            8'hF4: status <= status | BIT_REPORT;
            8'hF5: status <= status & ~BIT_REPORT;
            8'hF6, 8'hFF: begin
              status <= '0;
              res    <= DEF_RES;
              rate   <= DEF_RATE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r2_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rsp_valid && rsp_byte == ACK));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  a_r5_report_len: assert property (@(posedge clk) disable iff (!rst_n)
    (take && argw == W_NONE && cmd_byte == 8'hE9) |=> (cnt == CW'(4)));

  a_r4_report_on: assert property (@(posedge clk) disable iff (!rst_n)
    (take && argw == W_NONE && cmd_byte == 8'hF4) |=> status[5]);

  a_r7_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (take && argw == W_NONE && (cmd_byte == 8'hFF || cmd_byte == 8'hF6))
      |=> (status == 8'h00 && res == DEF_RES && rate == DEF_RATE));

  a_r8_res_arg: assert property (@(posedge clk) disable iff (!rst_n)
    (take && argw == W_RES) |=> (res == $past(cmd_byte) && argw == W_NONE));
endmodule

// File: tb/ps2_mouse_responder_tb_top.sv
`timescale 1ns/1ps
module ps2_mouse_responder_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 0;
  logic [7:0] cmd_byte = 0;
  logic cmd_ready, rsp_valid;
  logic [7:0] rsp_byte;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ps2_mouse_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_byte(rsp_byte));

  logic [7:0] m_status = 0, m_res = 2, m_rate = 100;
  int m_wait = 0;
  logic [7:0] exp_q [4];
  int exp_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] b);
    exp_q[0] = 8'hFA; exp_n = 1;
    if (m_wait == 1) begin m_res = b; m_wait = 0; end
    else if (m_wait == 2) begin m_rate = b; m_wait = 0; end
    else case (b)
      8'hE6: m_status = m_status & ~8'h10;
      8'hE8: m_wait = 1;
      8'hE9: begin exp_q[1] = m_status; exp_q[2] = m_res; exp_q[3] = m_rate; exp_n = 4; end
      8'hF2: begin exp_q[1] = 8'h00; exp_n = 2; end
      8'hF3: m_wait = 2;
      8'hF4: m_status = m_status | 8'h20;
      8'hF5: m_status = m_status & ~8'h20;
      8'hF6, 8'hFF: begin m_status = 0; m_res = 2; m_rate = 100; end
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    int got = 0, guard = 0;
    logic [7:0] prev = 0;
    bit stalled = 0;
    model(b);
    @(negedge clk);
    chk(cmd_ready === 1'b1, {tag, " R10 ready before send"}, cmd_ready, 1);
    cmd_valid = 1; cmd_byte = b;
    @(posedge clk); #1 cmd_valid = 0;
    while (got < exp_n && guard < 200) begin
      @(negedge clk);
      guard++;
      if (rsp_valid) chk(cmd_ready === 1'b0, "R10 busy input closed", cmd_ready, 0);
      if (stalled) chk(rsp_byte === prev, "R10 byte held", rsp_byte, prev);
      rsp_ready = 1'($urandom % 2);
      if (rsp_valid && rsp_ready) begin
        chk(rsp_byte === exp_q[got], tag, rsp_byte, exp_q[got]);
        got++;
        stalled = 0;
      end else begin
        stalled = rsp_valid;
        prev = rsp_byte;
      end
    end
    chk(got == exp_n, {tag, " reply length"}, got, exp_n);
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_valid === 1'b0, {tag, " no extra bytes R2"}, rsp_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [10];
    void'($urandom(32'd4711));
    codes = '{8'hE6, 8'hE8, 8'hE9, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFF, 8'h00};
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(cmd_ready === 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
    send(8'hE9, "R1 R5 report after reset");
    send(8'hF4, "R4 enable");
    send(8'hE9, "R4 R5 report");
    send(8'hE6, "R3 clear scaling");
    send(8'hE9, "R3 report");
    send(8'hF5, "R4 disable");
    send(8'hE9, "R4 report");
    send(8'hE8, "R8 res cmd");
    send(8'h03, "R8 res arg");
    send(8'hF3, "R8 rate cmd");
    send(8'hFF, "R8 rate arg FF");
    send(8'hE9, "R8 report");
    send(8'hE8, "R8 res cmd");
    send(8'hE9, "R8 res arg E9");
    send(8'hE9, "R8 report");
    send(8'hF2, "R6 id");
    send(8'h55, "R9 unknown");
    send(8'hE9, "R9 report");
    send(8'hF4, "R4 enable");
    send(8'hF6, "R7 defaults F6");
    send(8'hE9, "R7 report");
    send(8'hF3, "R8 rate cmd");
    send(8'h28, "R8 rate arg");
    send(8'hFF, "R7 reset FF");
    send(8'hE9, "R7 report");
    for (int i = 0; i < 400; i++) begin
      int k = $urandom % 14;
      logic [7:0] b = (k < 10) ? codes[k] : 8'($urandom);
      if (k == 9) b = 8'($urandom);
      send(b, "R2 random");
    end
    send(8'hE9, "R5 final report");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule